// File: doc/BRIEF.md
# Printer Port Register Handshake Model

This block is the byte-wide register file of a classic PC-style printer port. A host on a simple bus writes an output byte, writes a control byte and reads a status byte. No real printer is attached: the handshake a printer would perform is modelled inside the block. A rising strobe written through the control register sends the current output byte out on a one-cycle byte stream. Successive status reads walk the busy and acknowledge bits through their phases, and an interrupt request can be armed through the control register.

A separate input byte can be loaded from outside into an input latch. The host reads that latch in place of the output byte when the control register selects the input direction. Bus reads are combinational on `bus_rdata`. Every side effect of an access takes hold at the clock edge that ends it.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, offset 0 reads 0xFF, status (offset 1) reads 0xD9, control (offset 2) reads 0xCC, and both `irq` and `out_valid` are 0.
- R2: Bits 7 and 6 of every stored control value are 1, whatever value was written.
- R3: A control write with bit 2 (init) at 0 sets status to exactly 0xD8, which is bits 7, 6, 4 and 3.
- R4: A control write with bit 2 at 1, bit 3 (select) at 1 and bit 0 (strobe) at 1 clears status bit 7. If the previously stored strobe was 0, `out_valid` is high for exactly one cycle after the write, carrying the output byte. Otherwise no byte is sent. A strobe written with select at 0 does nothing.
- R5: A control write with init at 1, select at 1 and strobe at 0 sets the interrupt-pending flag, and so `irq`, only if the previously stored control had bit 4 (interrupt enable) at 1.
- R6: A status read returns the current status and clears `irq` at the end of the access. No other read clears it.
- R7: A status read made while status bit 7 is 0 and stored strobe is 0 advances the handshake. It clears bit 6 if bit 6 was set; otherwise it sets bits 6 and 7. Under any other condition a status read leaves status unchanged.
- R8: A read of offset 0 returns the input latch when control bit 5 is 1, and the last byte written to offset 0 otherwise.
- R9: Reads of offsets 3 to 7 return 0xFF. Writes to offsets other than 0 and 2 change no state.
- R10: `ext_load` captures `ext_data` into the input latch. A data read in the same cycle returns the previous latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, otherwise 0 |
| ext_load | input | 1 | Loads the input latch |
| ext_data | input | 8 | Byte for the input latch |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_byte | output | 8 | Emitted byte |
| irq | output | 1 | Interrupt request, equal to the pending flag |

## Verification
The input latch load and a host data read can land in the same cycle. The bench asserts `ext_load` and a read of offset 0, in input direction, on the same clock. It then expects the old latch value in that access and the new value in the next read. The emitted-byte stream is checked against a scoreboard queue that the driver fills on each qualifying 0-to-1 strobe. Repeated strobes, a strobe with select low, and a strobe following an init-low write check that exactly one byte appears per qualifying edge.

// File: rtl/prn_pkg.sv
// Shared offsets, bit positions and reset values for the printer port block.
// Assumes an 8-bit register width; bit positions are fixed by the port behaviour.
package prn_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] OFS_DATA = 3'd0;
    localparam logic [AW-1:0] OFS_STAT = 3'd1;
    localparam logic [AW-1:0] OFS_CTRL = 3'd2;

    localparam int CB_STROBE = 0;
    localparam int CB_INIT   = 2;
    localparam int CB_SEL    = 3;
    localparam int CB_INTEN  = 4;
    localparam int CB_DIR    = 5;

    localparam int SB_BUSYN  = 7;
    localparam int SB_ACK    = 6;

    localparam logic [DW-1:0] RST_DATA    = 8'hFF;
    localparam logic [DW-1:0] RST_STATUS  = 8'hD9;
    localparam logic [DW-1:0] RST_CTRL    = 8'hCC;
    localparam logic [DW-1:0] INIT_STATUS = 8'hD8;
    localparam logic [DW-1:0] CTRL_FORCE  = 8'hC0;
    localparam logic [DW-1:0] IDLE_READ   = 8'hFF;
endpackage

// File: rtl/prn_regfile.sv
// Holds the output byte, input latch and control register.
// Assumes the top has already forced the fixed control bits into ctrl_new.
module prn_regfile
    import prn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ctrl_new,
    input  logic          ext_load,
    input  logic [DW-1:0] ext_data,
    output logic [DW-1:0] dataw_q,
    output logic [DW-1:0] datar_q,
    output logic [DW-1:0] ctrl_q
);
    // Output byte written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       dataw_q <= RST_DATA;
        else if (data_wr) dataw_q <= wdata;
    end

    // Input latch loaded from outside.
    always_ff @(posedge clk) begin
        if (!rst_n)        datar_q <= RST_DATA;
        else if (ext_load) datar_q <= ext_data;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= RST_CTRL;
        else if (ctrl_wr) ctrl_q <= ctrl_new;
    end

    assert_ctrl_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q[7:6] == 2'b11));
endmodule

// File: rtl/prn_handshake.sv
// Status register, emulated printer handshake, interrupt pending flag and byte emission.
// Assumes a control write and a status read never share a cycle (distinct offsets).
module prn_handshake
    import prn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          new_init,
    input  logic          new_sel,
    input  logic          new_strobe,
    input  logic          prev_strobe,
    input  logic          prev_inten,
    input  logic          stat_rd,
    input  logic [DW-1:0] dataw_q,
    output logic [DW-1:0] status_q,
    output logic          irq,
    output logic          out_valid,
    output logic [DW-1:0] out_byte
);
    logic sel_live;
    logic strobe_hit;
    logic arm_irq;
    logic advance;

    // Decode the qualifying control-write cases and the handshake advance.
    always_comb begin
        sel_live   = ctrl_wr && new_init && new_sel;
        strobe_hit = sel_live && new_strobe;
        arm_irq    = sel_live && !new_strobe && prev_inten;
        advance    = stat_rd && !status_q[SB_BUSYN] && !prev_strobe;
    end

    // Status register: init forcing, strobe clears busy, reads walk ack/busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RST_STATUS;
        end else if (ctrl_wr && !new_init) begin
            status_q <= INIT_STATUS;
        end else if (strobe_hit) begin
            status_q[SB_BUSYN] <= 1'b0;
        end else if (advance) begin
            if (status_q[SB_ACK]) status_q[SB_ACK] <= 1'b0;
            else                  status_q[SB_BUSYN:SB_ACK] <= 2'b11;
        end
    end

    // Interrupt pending flag, cleared by status reads.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (stat_rd) irq <= 1'b0;
        else if (arm_irq) irq <= 1'b1;
    end

    // One-cycle byte emission on a rising strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= strobe_hit && !prev_strobe;
            if (strobe_hit && !prev_strobe) out_byte <= dataw_q;
        end
    end

    assert_init_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !new_init) |=> (status_q == INIT_STATUS));
    assert_emit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(ctrl_wr && new_strobe && new_sel && new_init && !prev_strobe));
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl_wr && prev_inten && !new_strobe));
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !irq);
endmodule

// File: rtl/prn_rdmux.sv
// Read data multiplexer: selects the register at the offset, 0xFF for unmapped offsets.
// Assumes reads are side-effect free here; effects live in the handshake block.
module prn_rdmux
    import prn_pkg::*;
(
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic          dir_in,
    input  logic [DW-1:0] dataw_q,
    input  logic [DW-1:0] datar_q,
    input  logic [DW-1:0] status_q,
    input  logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] rdata
);
    // Pick the read value for the addressed register.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                OFS_DATA: rdata = dir_in ? datar_q : dataw_q;
                OFS_STAT: rdata = status_q;
                OFS_CTRL: rdata = ctrl_q;
                default:  rdata = IDLE_READ;
            endcase
        end
    end
endmodule

// File: rtl/prn_port_regs.sv
// Top of the printer port register model: decodes bus accesses and wires the
// register file, handshake and read mux. Assumes bus_wr and bus_rd are one-cycle strobes.
module prn_port_regs
    import prn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_load,
    input  logic [DW-1:0] ext_data,
    output logic          out_valid,
    output logic [DW-1:0] out_byte,
    output logic          irq
);
    logic          data_wr, ctrl_wr, stat_rd;
    logic [DW-1:0] ctrl_new, dataw_q, datar_q, ctrl_q, status_q;

    // Bus decode and forcing of the fixed control bits.
    always_comb begin
        data_wr  = bus_wr && (bus_addr == OFS_DATA);
        ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
        stat_rd  = bus_rd && !bus_wr && (bus_addr == OFS_STAT);
        ctrl_new = bus_wdata | CTRL_FORCE;
    end

    prn_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .wdata(bus_wdata), .ctrl_new(ctrl_new), .ext_load(ext_load),
        .ext_data(ext_data), .dataw_q(dataw_q), .datar_q(datar_q), .ctrl_q(ctrl_q)
    );

    prn_handshake u_hs (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .new_init(ctrl_new[CB_INIT]), .new_sel(ctrl_new[CB_SEL]),
        .new_strobe(ctrl_new[CB_STROBE]), .prev_strobe(ctrl_q[CB_STROBE]),
        .prev_inten(ctrl_q[CB_INTEN]), .stat_rd(stat_rd), .dataw_q(dataw_q),
        .status_q(status_q), .irq(irq), .out_valid(out_valid), .out_byte(out_byte)
    );

    prn_rdmux u_mux (
        .rd(bus_rd), .addr(bus_addr), .dir_in(ctrl_q[CB_DIR]), .dataw_q(dataw_q),
        .datar_q(datar_q), .status_q(status_q), .ctrl_q(ctrl_q), .rdata(bus_rdata)
    );

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > OFS_CTRL) |-> (bus_rdata == IDLE_READ));
endmodule

// File: tb/prn_port_regs_bench.sv
module prn_port_regs_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 0, bus_rd = 0, ext_load = 0;
    logic [7:0] bus_wdata = '0, ext_data = '0;
    logic [7:0] bus_rdata, out_byte;
    logic       out_valid, irq;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    prn_port_regs u_prn_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_load(ext_load), .ext_data(ext_data), .out_valid(out_valid),
        .out_byte(out_byte), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] got;
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #2 got = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
        check(req, got, exp);
    endtask

    task automatic strobe(input logic [7:0] d, input logic [7:0] byte_exp);
        exp_q.push_back(byte_exp);
        wr(3'd2, d);
    endtask

    // Scoreboard monitor: every emitted byte must match the next expected one.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) check("R4 unexpected byte", out_byte, 8'hxx);
            else check("R4 byte", out_byte, exp_q.pop_front());
        end
    end

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog got=hang exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 out_valid", {7'd0, out_valid}, 8'h00);
        rd(3'd0, 8'hFF, "R1 data");
        rd(3'd1, 8'hD9, "R1 status");
        rd(3'd2, 8'hCC, "R1 control");
        rd(3'd3, 8'hFF, "R9 offset3");
        rd(3'd7, 8'hFF, "R9 offset7");

        wr(3'd0, 8'h5A);
        rd(3'd0, 8'h5A, "R8 output dir");
        strobe(8'h0D, 8'h5A);
        rd(3'd1, 8'h59, "R4 busy cleared");
        wr(3'd2, 8'h0D);                       // repeated strobe: no byte
        rd(3'd2, 8'hCD, "R2 forced bits");
        wr(3'd2, 8'h0C);
        check("R5 no enable", {7'd0, irq}, 8'h00);
        rd(3'd1, 8'h59, "R7 phase a");
        rd(3'd1, 8'h19, "R7 phase b");
        rd(3'd1, 8'hD9, "R7 phase c");
        rd(3'd1, 8'hD9, "R7 stable");

        wr(3'd0, 8'hA3);
        wr(3'd2, 8'h05);                       // strobe with select low: nothing
        rd(3'd1, 8'hD9, "R4 select low");
        wr(3'd2, 8'h0D);                       // previous strobe already 1
        rd(3'd1, 8'h59, "R4 no edge");
        wr(3'd2, 8'h0C);
        strobe(8'h0D, 8'hA3);

        wr(3'd2, 8'h1C);
        check("R5 enable only now", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1C);
        check("R5 irq set", {7'd0, irq}, 8'h01);
        rd(3'd0, 8'hA3, "R6 data read");
        check("R6 irq kept", {7'd0, irq}, 8'h01);
        rd(3'd1, 8'h59, "R6 status value");
        check("R6 irq cleared", {7'd0, irq}, 8'h00);

        wr(3'd2, 8'h18);
        rd(3'd1, 8'hD8, "R3 init status");
        rd(3'd2, 8'hD8, "R2 init control");
        wr(3'd0, 8'h77);
        strobe(8'h0D, 8'h77);
        wr(3'd1, 8'h00);
        rd(3'd1, 8'h58, "R9 status write ignored");
        wr(3'd5, 8'h12);
        rd(3'd0, 8'h77, "R9 offset5 write ignored");

        wr(3'd2, 8'h2C);
        rd(3'd0, 8'hFF, "R8 input latch reset");
        @(negedge clk); ext_data = 8'h3C; ext_load = 1;
        @(posedge clk); #1 ext_load = 0;
        rd(3'd0, 8'h3C, "R10 load");
        @(negedge clk);
        ext_data = 8'h81; ext_load = 1; bus_addr = 3'd0; bus_rd = 1;
        #2 check("R10 same cycle old", bus_rdata, 8'h3C);
        @(posedge clk); #1 ext_load = 0; bus_rd = 0;
        rd(3'd0, 8'h81, "R10 new value");
        wr(3'd2, 8'h0C);
        rd(3'd0, 8'h77, "R8 back to output");

        repeat (4) @(posedge clk);
        check("R4 all bytes seen", 8'(exp_q.size()), 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule